// File: doc/BRIEF.md
# Encoder Count Channel with Preload, Latch and Dual Compare

This block is one position-counting channel for a rotary or linear encoder. An upstream decoder turns the encoder waveforms into a per-clock count enable and a direction bit. The channel keeps a 24-bit binary position that steps up or down on each enabled clock and wraps modulo 2^24 in both directions.

Three pin strobes act on the position. A load strobe copies a software-written preload value into the counter. A latch strobe takes a snapshot of the position without disturbing counting. A zeroing input, usually tied to the encoder index mark, clears the counter either at the next clock edge or at once, as a control bit selects.

Two 24-bit reference values are compared with the registered count on every clock. Each comparison gives a live equal flag and a sticky copy of that flag. Two external pins carry these flags. In command mode 0 only the first comparator runs and the second pin acts as a general input. In command mode 1 both comparators run, and each pin shows one of three selectable sources. All registers are reached through a flat register port with a combinational read path.

Top module: `enc_count_channel`

## Requirements
- R1: With `cnt_en` high and no load or clear, each rising clock edge adds one to the count when `cnt_dir` is 1 and subtracts one when it is 0. The count wraps from 0xFFFFFF to 0 and from 0 to 0xFFFFFF.
- R2: `load_strb` high at an edge copies the preload register into the count, and it takes priority over counting in that cycle.
- R3: `latch_strb` high at an edge stores the count held just before that edge into the latch register, and counting in that cycle goes on unchanged.
- R4: `idx_clr` zeroes the count and wins over both load and counting. With control bit 5 = 0 the count becomes zero at the next edge. With control bit 5 = 1 the count reads zero while `idx_clr` is high, before any edge.
- R5: Equal flags are registered. EQA (status bit 0) and EQB (status bit 1) go high on the edge after the one where the count first equals reference A or reference B. In mode 0, EQB and the B hold flag stay 0.
- R6: Hold flags (status bit 2 for A, bit 3 for B) set whenever the matching comparison is true. They stay set until a status write with a 1 in that bit, and a compare hit in the same cycle wins over the clear.
- R7: In mode 0 (control bit 0 = 0), `ext_a_o` equals EQA and `ext_b_oe` is 0. Status bit 4 shows the level of `ext_b_i` sampled one clock earlier.
- R8: In mode 1 the select field in control bits 2:1 chooses `ext_a_o`: 0 gives EQA, 1 gives EQA OR EQB, 2 gives the A hold flag, and 3 acts as 0.
- R9: In mode 1 `ext_b_oe` is 1, and control bits 4:3 choose `ext_b_o`: 0 gives EQB, 1 gives the abnormal-input flag, 2 gives the B hold flag, and 3 acts as 0.
- R10: `abn_i` high at an edge sets a sticky abnormal flag in status bit 5. A status write with a 1 in bit 5 clears it, and a new `abn_i` in the same cycle wins.
- R11: While `rst_n` is low, the count, latch, preload, references, control and status all read 0, and both external outputs and `ext_b_oe` are 0.
- R12: Register map, selected by `reg_addr`: 0 count (read only), 1 preload, 2 latch (read only), 3 reference A, 4 reference B, 5 control (bits 5:0), 6 status (bits 5:0, write-one-to-clear for bits 2, 3 and 5). Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count step request from the decoder |
| cnt_dir | input | 1 | Step direction, 1 = up |
| load_strb | input | 1 | Copy preload into the count |
| latch_strb | input | 1 | Snapshot the count into the latch |
| idx_clr | input | 1 | Index / zeroing input |
| abn_i | input | 1 | Abnormal-input pulse from the decoder |
| ext_b_i | input | 1 | Second pin input level, used in mode 0 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data, combinational |
| ext_a_o | output | 1 | First external pin |
| ext_b_o | output | 1 | Second external pin, output value |
| ext_b_oe | output | 1 | Output enable for the second pin |

## Verification
A wrong count value shows up on the count readback at the first check after the faulty edge. It then spreads into the latch readback at the next latch strobe and into the equal flags one clock later. A flipped priority between clear, load and counting produces a nonzero count in the very cycle where zero or the preload value is expected. A comparator or hold register stuck at the wrong level appears on `ext_a_o` or `ext_b_o` at once when the pin multiplexer selects it, and in the status readback within one cycle. A synchronous clear that behaves as asynchronous, or the reverse, shows on the count readback taken between the rise of `idx_clr` and the next edge.

// File: rtl/enc_count_pkg.sv
package enc_count_pkg;

    localparam int ADDR_W = 3;
    localparam int CTRL_W = 6;
    localparam int STAT_W = 6;
    localparam int NCMP   = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_COUNT   = 3'd0,
        RA_PRELOAD = 3'd1,
        RA_LATCH   = 3'd2,
        RA_REFA    = 3'd3,
        RA_REFB    = 3'd4,
        RA_CTRL    = 3'd5,
        RA_STATUS  = 3'd6
    } reg_addr_e;

    // control register layout, LSB first: mode, pin A select, pin B select, clear style
    typedef struct packed {
        logic       clr_async;
        logic [1:0] sel_b;
        logic [1:0] sel_a;
        logic       mode;
    } ctrl_t;

    localparam logic [1:0] SA_EQ   = 2'd0;
    localparam logic [1:0] SA_OR   = 2'd1;
    localparam logic [1:0] SA_HOLD = 2'd2;
    localparam logic [1:0] SB_EQ   = 2'd0;
    localparam logic [1:0] SB_ABN  = 2'd1;
    localparam logic [1:0] SB_HOLD = 2'd2;

    localparam int ST_EQ0   = 0;
    localparam int ST_HOLD0 = 2;
    localparam int ST_GP    = 4;
    localparam int ST_ABN   = 5;

endpackage

// File: rtl/enc_cnt_core.sv
module enc_cnt_core #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         cnt_dir,
    input  logic         load_strb,
    input  logic         latch_strb,
    input  logic         idx_clr,
    input  logic         clr_async,
    input  logic [W-1:0] preload,
    output logic [W-1:0] count_q,
    output logic [W-1:0] latch_q
);

    typedef struct packed {
        logic [W-1:0] count;
        logic [W-1:0] latch;
    } core_st_t;

    localparam logic [W-1:0] ONE = W'(1);

    core_st_t st_d;
    logic     aclr;

    always_comb begin
        st_d.count = count_q;
        st_d.latch = latch_q;
        if (idx_clr) begin
            st_d.count = '0;
        end else if (load_strb) begin
            st_d.count = preload;
        end else if (cnt_en) begin
            st_d.count = cnt_dir ? (count_q + ONE) : (count_q - ONE);
        end
        if (latch_strb) begin
            st_d.latch = count_q;
        end
    end

    assign aclr = idx_clr & clr_async;

    always_ff @(posedge clk or negedge rst_n or posedge aclr) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (aclr) begin
            count_q <= '0;
        end else begin
            count_q <= st_d.count;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            latch_q <= st_d.latch;
        end
    end

endmodule

// File: rtl/enc_cmp.sv
module enc_cmp #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic [W-1:0] count,
    input  logic [W-1:0] ref_val,
    input  logic         hold_clr,
    output logic         eq_q,
    output logic         hold_q
);

    typedef struct packed {
        logic eq;
        logic hold;
    } cmp_st_t;

    cmp_st_t st_d;
    cmp_st_t st_q;
    logic    hit;

    always_comb begin
        hit       = enable && (count == ref_val);
        st_d.eq   = hit;
        st_d.hold = hit | (st_q.hold & ~hold_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eq_q   = st_q.eq;
    assign hold_q = st_q.hold;

endmodule

// File: rtl/enc_pin_mux.sv
module enc_pin_mux
    import enc_count_pkg::*;
(
    input  logic            mode,
    input  logic [1:0]      sel_a,
    input  logic [1:0]      sel_b,
    input  logic [NCMP-1:0] eq,
    input  logic [NCMP-1:0] hold,
    input  logic            abn,
    output logic            ext_a_o,
    output logic            ext_b_o,
    output logic            ext_b_oe
);

    always_comb begin
        ext_a_o  = eq[0];
        ext_b_o  = 1'b0;
        ext_b_oe = mode;
        if (mode) begin
            case (sel_a)
                SA_OR:   ext_a_o = eq[0] | eq[1];
                SA_HOLD: ext_a_o = hold[0];
                default: ext_a_o = eq[0];
            endcase
            case (sel_b)
                SB_ABN:  ext_b_o = abn;
                SB_HOLD: ext_b_o = hold[1];
                default: ext_b_o = eq[1];
            endcase
        end
    end

endmodule

// File: rtl/enc_count_channel.sv
module enc_count_channel
    import enc_count_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              cnt_dir,
    input  logic              load_strb,
    input  logic              latch_strb,
    input  logic              idx_clr,
    input  logic              abn_i,
    input  logic              ext_b_i,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              ext_a_o,
    output logic              ext_b_o,
    output logic              ext_b_oe
);

    localparam int PAD_C = CNT_W - CTRL_W;
    localparam int PAD_S = CNT_W - STAT_W;

    typedef struct packed {
        logic [CNT_W-1:0]            preload;
        logic [NCMP-1:0][CNT_W-1:0]  refs;
        ctrl_t                       ctrl;
        logic                        abn;
        logic                        gp;
    } regs_t;

    regs_t regs_d;
    regs_t regs_q;

    logic                  wr_stat;
    logic [NCMP-1:0]       hold_clr;
    logic [NCMP-1:0]       eq_w;
    logic [NCMP-1:0]       hold_w;
    logic [CNT_W-1:0]      count_w;
    logic [CNT_W-1:0]      latch_w;
    logic [CNT_W-1:0]      preload_w;
    logic                  abn_w;
    logic [STAT_W-1:0]     status_w;

    assign wr_stat = reg_wr && (reg_addr == RA_STATUS);

    always_comb begin
        regs_d    = regs_q;
        regs_d.gp = ext_b_i;
        if (reg_wr) begin
            case (reg_addr)
                RA_PRELOAD: regs_d.preload = reg_wdata;
                RA_REFA:    regs_d.refs[0] = reg_wdata;
                RA_REFB:    regs_d.refs[1] = reg_wdata;
                RA_CTRL:    regs_d.ctrl    = ctrl_t'(reg_wdata[CTRL_W-1:0]);
                default:    ;
            endcase
        end
        if (wr_stat && reg_wdata[ST_ABN]) begin
            regs_d.abn = 1'b0;
        end
        if (abn_i) begin
            regs_d.abn = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign preload_w = regs_q.preload;
    assign abn_w     = regs_q.abn;

    enc_cnt_core #(.W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .cnt_dir    (cnt_dir),
        .load_strb  (load_strb),
        .latch_strb (latch_strb),
        .idx_clr    (idx_clr),
        .clr_async  (regs_q.ctrl.clr_async),
        .preload    (preload_w),
        .count_q    (count_w),
        .latch_q    (latch_w)
    );

    for (genvar gi = 0; gi < NCMP; gi++) begin : g_cmp
        assign hold_clr[gi] = wr_stat && reg_wdata[ST_HOLD0 + gi];
        enc_cmp #(.W(CNT_W)) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   ((gi == 0) ? 1'b1 : regs_q.ctrl.mode),
            .count    (count_w),
            .ref_val  (regs_q.refs[gi]),
            .hold_clr (hold_clr[gi]),
            .eq_q     (eq_w[gi]),
            .hold_q   (hold_w[gi])
        );
    end

    enc_pin_mux u_mux (
        .mode     (regs_q.ctrl.mode),
        .sel_a    (regs_q.ctrl.sel_a),
        .sel_b    (regs_q.ctrl.sel_b),
        .eq       (eq_w),
        .hold     (hold_w),
        .abn      (abn_w),
        .ext_a_o  (ext_a_o),
        .ext_b_o  (ext_b_o),
        .ext_b_oe (ext_b_oe)
    );

    always_comb begin
        status_w             = '0;
        status_w[ST_EQ0+:2]  = eq_w;
        status_w[ST_HOLD0+:2] = hold_w;
        status_w[ST_GP]      = regs_q.gp & ~regs_q.ctrl.mode;
        status_w[ST_ABN]     = regs_q.abn;
    end

    always_comb begin
        case (reg_addr)
            RA_COUNT:   reg_rdata = count_w;
            RA_PRELOAD: reg_rdata = regs_q.preload;
            RA_LATCH:   reg_rdata = latch_w;
            RA_REFA:    reg_rdata = regs_q.refs[0];
            RA_REFB:    reg_rdata = regs_q.refs[1];
            RA_CTRL:    reg_rdata = {{PAD_C{1'b0}}, regs_q.ctrl};
            RA_STATUS:  reg_rdata = {{PAD_S{1'b0}}, status_w};
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/enc_count_checker.sv
module enc_count_checker
    import enc_count_pkg::*;
#(
    parameter int W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_en,
    input logic              cnt_dir,
    input logic              load_strb,
    input logic              latch_strb,
    input logic              idx_clr,
    input logic              abn_i,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [W-1:0]      reg_wdata,
    input logic [W-1:0]      preload,
    input logic [W-1:0]      count,
    input logic [W-1:0]      latched,
    input logic [NCMP-1:0]   hold,
    input logic              abn_flag
);

    localparam logic [W-1:0] ONE = W'(1);

    logic clr_hold_a;
    assign clr_hold_a = reg_wr && (reg_addr == RA_STATUS) && reg_wdata[ST_HOLD0];

    // R1
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && cnt_dir && !load_strb && !idx_clr) |=> (count == $past(count) + ONE));

    // R1
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_dir && !load_strb && !idx_clr) |=> (count == $past(count) - ONE));

    // R2
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_strb && !idx_clr) |=> (count == $past(preload)));

    // R3
    latch_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_strb |=> (latched == $past(count)));

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_clr |=> (count == '0));

    // R6
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold[0] && !clr_hold_a) |=> hold[0]);

    // R10
    abn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abn_i |=> abn_flag);

endmodule

bind enc_count_channel enc_count_checker #(.W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .cnt_dir    (cnt_dir),
    .load_strb  (load_strb),
    .latch_strb (latch_strb),
    .idx_clr    (idx_clr),
    .abn_i      (abn_i),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .preload    (preload_w),
    .count      (count_w),
    .latched    (latch_w),
    .hold       (hold_w),
    .abn_flag   (abn_w)
);

// File: tb/enc_count_channel_test.sv
module enc_count_channel_test;

    localparam int CLK_P = 10;
    localparam int W     = 24;
    localparam int NVEC  = 13;

    localparam logic [2:0] A_COUNT  = 3'd0;
    localparam logic [2:0] A_PRE    = 3'd1;
    localparam logic [2:0] A_LATCH  = 3'd2;
    localparam logic [2:0] A_REFA   = 3'd3;
    localparam logic [2:0] A_REFB   = 3'd4;
    localparam logic [2:0] A_CTRL   = 3'd5;
    localparam logic [2:0] A_STATUS = 3'd6;

    // {en, dir, load, latch, clr, expected count, expected latch}
    localparam logic [52:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 24'h000001, 24'h000000},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 24'h000002, 24'h000000},
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 24'h000001, 24'h000000},
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 24'h000000, 24'h000000},
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 24'hFFFFFF, 24'h000000},
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 24'hFFFFFE, 24'h000000},
        {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 24'hFFFFFF, 24'hFFFFFE},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 24'h000000, 24'hFFFFFE},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 24'h000001, 24'hFFFFFE},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 24'h000000, 24'hFFFFFE},
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 24'h000000, 24'hFFFFFE},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 24'h000000, 24'hFFFFFE},
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 24'hFFFFFE, 24'hFFFFFE}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b0;
    logic         cnt_dir = 1'b0;
    logic         load_strb = 1'b0;
    logic         latch_strb = 1'b0;
    logic         idx_clr = 1'b0;
    logic         abn_i = 1'b0;
    logic         ext_b_i = 1'b0;
    logic         reg_wr = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         ext_a_o;
    logic         ext_b_o;
    logic         ext_b_oe;

    int total = 0;
    int bad   = 0;
    logic [W-1:0] rv;

    enc_count_channel #(.CNT_W(W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .cnt_dir    (cnt_dir),
        .load_strb  (load_strb),
        .latch_strb (latch_strb),
        .idx_clr    (idx_clr),
        .abn_i      (abn_i),
        .ext_b_i    (ext_b_i),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ext_a_o    (ext_a_o),
        .ext_b_o    (ext_b_o),
        .ext_b_oe   (ext_b_oe)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        tick();
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    initial begin
        #(CLK_P * 20000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R11 reset state
        ext_b_i = 1'b1;
        tick();
        tick();
        rd(A_COUNT, rv);  chk("R11 count in reset", rv, '0);
        rd(A_CTRL, rv);   chk("R11 control in reset", rv, '0);
        rd(A_STATUS, rv); chk("R11 status in reset", rv, '0);
        rd(A_LATCH, rv);  chk("R11 latch in reset", rv, '0);
        chk("R11 pins in reset", {21'd0, ext_a_o, ext_b_o, ext_b_oe}, '0);
        ext_b_i = 1'b0;
        rst_n = 1'b1;
        tick();

        // R12 preload register readback
        wr(A_PRE, 24'hFFFFFE);
        rd(A_PRE, rv); chk("R12 preload readback", rv, 24'hFFFFFE);

        // table walk: R1 stepping and wrap, R2 load, R3 latch, R4 clear priority
        for (int i = 0; i < NVEC; i++) begin
            cnt_en     = VEC[i][52];
            cnt_dir    = VEC[i][51];
            load_strb  = VEC[i][50];
            latch_strb = VEC[i][49];
            idx_clr    = VEC[i][48];
            tick();
            cnt_en = 1'b0; cnt_dir = 1'b0; load_strb = 1'b0;
            latch_strb = 1'b0; idx_clr = 1'b0;
            rd(A_COUNT, rv); chk($sformatf("R1 R2 R4 vector %0d count", i), rv, VEC[i][47:24]);
            rd(A_LATCH, rv); chk($sformatf("R3 vector %0d latch", i), rv, VEC[i][23:0]);
        end

        // R4 synchronous clear waits for the edge
        idx_clr = 1'b1;
        rd(A_COUNT, rv); chk("R4 sync clear before edge", rv, 24'hFFFFFE);
        tick();
        idx_clr = 1'b0;
        rd(A_COUNT, rv); chk("R4 sync clear after edge", rv, '0);

        // R4 asynchronous clear acts before the edge
        wr(A_CTRL, 24'h000020);
        load_strb = 1'b1; tick(); load_strb = 1'b0;
        tick();
        rd(A_COUNT, rv); chk("R2 load before async clear", rv, 24'hFFFFFE);
        idx_clr = 1'b1;
        rd(A_COUNT, rv); chk("R4 async clear before edge", rv, '0);
        tick();
        idx_clr = 1'b0;
        rd(A_COUNT, rv); chk("R4 async clear after edge", rv, '0);
        wr(A_CTRL, 24'h000000);

        // mode 0 compare: R5 lag, R6 hold, R7 pins
        wr(A_REFA, 24'd3);
        wr(A_REFB, 24'd4);
        wr(A_STATUS, 24'h00003C);
        rd(A_STATUS, rv); chk("R6 hold cleared by write", rv, '0);
        cnt_dir = 1'b1;
        cnt_en = 1'b1; tick(); tick(); tick(); cnt_en = 1'b0;
        chk("R5 no equal in match cycle", {23'd0, ext_a_o}, '0);
        tick();
        chk("R5 R7 equal A on pin", {23'd0, ext_a_o}, 24'd1);
        rd(A_STATUS, rv); chk("R5 R6 status at match", rv, 24'h05);
        cnt_en = 1'b1; tick(); cnt_en = 1'b0;
        chk("R5 equal lags count", {23'd0, ext_a_o}, 24'd1);
        tick();
        chk("R5 equal drops", {23'd0, ext_a_o}, '0);
        rd(A_STATUS, rv); chk("R5 R6 hold A kept, B idle in mode 0", rv, 24'h04);
        chk("R7 pin B not driven", {23'd0, ext_b_oe}, '0);
        ext_b_i = 1'b1; tick();
        rd(A_STATUS, rv); chk("R7 general input high", rv, 24'h14);
        ext_b_i = 1'b0; tick();
        rd(A_STATUS, rv); chk("R7 general input low", rv, 24'h04);

        // mode 1 pin selects: R8, R9
        wr(A_CTRL, 24'h000003);
        tick();
        chk("R8 pin A shows EQA or EQB", {23'd0, ext_a_o}, 24'd1);
        chk("R9 pin B driven", {23'd0, ext_b_oe}, 24'd1);
        chk("R9 pin B shows EQB", {23'd0, ext_b_o}, 24'd1);
        wr(A_CTRL, 24'h000001);
        chk("R8 pin A shows EQA", {23'd0, ext_a_o}, '0);
        wr(A_CTRL, 24'h000005);
        chk("R8 pin A shows hold A", {23'd0, ext_a_o}, 24'd1);
        wr(A_STATUS, 24'h000004);
        chk("R6 R8 hold A cleared on pin", {23'd0, ext_a_o}, '0);
        rd(A_STATUS, rv); chk("R6 status after hold A clear", rv, 24'h0A);
        wr(A_CTRL, 24'h000011);
        cnt_en = 1'b1; tick(); cnt_en = 1'b0;
        tick();
        chk("R9 pin B shows hold B", {23'd0, ext_b_o}, 24'd1);
        rd(A_STATUS, rv); chk("R5 R6 EQB gone, hold B kept", rv, 24'h08);

        // R10 abnormal flag, routed through pin B
        wr(A_CTRL, 24'h000009);
        chk("R9 pin B shows abnormal idle", {23'd0, ext_b_o}, '0);
        abn_i = 1'b1; tick(); abn_i = 1'b0;
        chk("R10 abnormal set", {23'd0, ext_b_o}, 24'd1);
        tick();
        chk("R10 abnormal sticky", {23'd0, ext_b_o}, 24'd1);
        rd(A_STATUS, rv); chk("R10 status abnormal bit", rv, 24'h28);
        wr(A_STATUS, 24'h000020);
        chk("R10 abnormal cleared", {23'd0, ext_b_o}, '0);
        rd(A_STATUS, rv); chk("R10 status after clear", rv, 24'h08);
        rd(3'd7, rv); chk("R12 unused address", rv, '0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule